// File: doc/BRIEF.md
# Cut-Through Packet Switch Node

This block is a small switching point for a network of computing elements on one chip. Every neighbour is reached over a point-to-point channel built from two FIFOs, one per direction. On each of its inputs the node sees the head of a first-word-fall-through FIFO. On each of its outputs it pushes into the write side of a FIFO. The first word of a packet is a header that names a destination rank and a payload length. The node looks the rank up in a writable routing table to choose an output. It then streams the whole packet from the input FIFO to the output FIFO, one word per cycle. Each word moves as soon as it is present, and nothing is held inside the node.

When several inputs want the same idle output, they take turns in round-robin order. A granted output stays tied to its packet until the last payload word has gone through. The only flow control is the FIFO status: a full output FIFO stops the pop on the input that owns it, so the stall reaches the sender. A free output that is not full carries a header out one cycle after that header reaches the head of its input FIFO.

Top module: `cnoc_node`

## Requirements
- R1: A header word carries the destination rank in bits [31:24] and the payload word count in bits [7:0]. A packet is that header followed by exactly that many payload words.
- R2: The output for a packet is the routing table entry indexed by the header's rank. A table write (tbl_we, tbl_rank, tbl_port) applies to every header that reaches an input head after the clock edge that takes the write.
- R3: After reset, every table entry selects output 0.
- R4: Take a header that reaches the head of an input FIFO while its output is unlocked and not full. It is written to that output in the next cycle, in the same cycle it is popped.
- R5: An output is written only while its full flag is low. While it is full, the input that owns it is not popped.
- R6: Every pop of an input is, in the same cycle, a write of that same word to exactly one output. An input is never popped while its exists flag is low, and no word is lost, duplicated or altered.
- R7: Once an output is granted to a packet, it carries only that packet's words until the last payload word has passed. Packets never interleave on an output.
- R8: Inputs that contend for one unlocked output are granted in round-robin order. After reset the order starts at input 0, and each grant moves the turn to the input just after the winner.
- R9: While reset is high, no input is popped and no output is written.
- R10: A header with a payload count of 0 is carried as a one-word packet and releases its output right after that word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_data | input | NPORT x 32 | Head word of each input FIFO |
| in_exists | input | NPORT | Input FIFO holds at least one word |
| in_read | output | NPORT | Pop strobe for each input FIFO |
| out_data | output | NPORT x 32 | Word pushed to each output FIFO |
| out_write | output | NPORT | Push strobe for each output FIFO |
| out_full | input | NPORT | Output FIFO cannot take a word |
| tbl_we | input | 1 | Routing table write enable |
| tbl_rank | input | 8 | Table entry (destination rank) to write |
| tbl_port | input | log2(NPORT) | Output number stored in that entry |

## Verification
A wrong word count in an input's lock shows up at the packet boundary. Either the next header is swallowed as payload, or payload words are taken for a header with no matching packet. The scoreboard catches this on the first misplaced word. A wrong owner or a stuck lock on an output interleaves two packets or stalls the port. Both appear within the packet at fault, through the word-by-word comparison and the emptiness check at the end. A bad round-robin pointer or a bad table entry changes the header order or the exit port on the very next contended grant. Cut-through timing is pinned by counting cycles from the arrival of a header at its input head to its exit.

// File: rtl/cnoc_pkg.sv
package cnoc_pkg;

    localparam int WORD_W    = 32;
    localparam int RANK_W    = 8;
    localparam int LEN_W     = 8;
    localparam int TAG_W     = WORD_W - RANK_W - LEN_W;
    localparam int TBL_DEPTH = 1 << RANK_W;

    // Header layout: rank in the top byte, payload count in the low byte.
    typedef struct packed {
        logic [RANK_W-1:0] rank;
        logic [TAG_W-1:0]  tag;
        logic [LEN_W-1:0]  len;
    } hdr_t;

    function automatic logic [RANK_W-1:0] hdr_rank(input logic [WORD_W-1:0] w);
        hdr_t h;
        h = hdr_t'(w);
        return h.rank;
    endfunction

    function automatic logic [LEN_W-1:0] hdr_len(input logic [WORD_W-1:0] w);
        hdr_t h;
        h = hdr_t'(w);
        return h.len;
    endfunction

endpackage

// File: rtl/cnoc_route_tbl.sv
module cnoc_route_tbl
    import cnoc_pkg::*;
#(
    parameter  int NPORT = 4,
    localparam int PW    = (NPORT > 1) ? $clog2(NPORT) : 1
) (
    input  logic                           clk,
    input  logic                           rst,
    input  logic                           wr_en,
    input  logic [RANK_W-1:0]              wr_rank,
    input  logic [PW-1:0]                  wr_port,
    input  logic [NPORT-1:0][RANK_W-1:0]   lk_rank,
    output logic [NPORT-1:0][PW-1:0]       lk_port
);

    logic [PW-1:0] ent [TBL_DEPTH];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int k = 0; k < TBL_DEPTH; k++) ent[k] <= '0;
        end else if (wr_en) begin
            ent[wr_rank] <= wr_port;
        end
    end

    for (genvar g = 0; g < NPORT; g++) begin : g_look
        assign lk_port[g] = ent[lk_rank[g]];
    end

endmodule

// File: rtl/cnoc_rr_arb.sv
module cnoc_rr_arb #(
    parameter  int NPORT = 4,
    localparam int PW    = (NPORT > 1) ? $clog2(NPORT) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [NPORT-1:0] req,
    output logic [NPORT-1:0] gnt,
    output logic [PW-1:0]    gnt_idx
);

    logic [PW-1:0] ptr;

    always_comb begin
        int  idx;
        logic found;
        gnt     = '0;
        gnt_idx = '0;
        found   = 1'b0;
        for (int k = 0; k < NPORT; k++) begin
            idx = (int'(ptr) + k) % NPORT;
            if (!found && req[idx]) begin
                found        = 1'b1;
                gnt[idx]     = 1'b1;
                gnt_idx      = PW'(idx);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ptr <= '0;
        end else if (|req) begin
            ptr <= (int'(gnt_idx) == NPORT - 1) ? '0 : gnt_idx + 1'b1;
        end
    end

endmodule

// File: rtl/cnoc_in_track.sv
module cnoc_in_track
    import cnoc_pkg::*;
#(
    parameter  int NPORT = 4,
    localparam int PW    = (NPORT > 1) ? $clog2(NPORT) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             take,
    input  logic [PW-1:0]    take_port,
    input  logic [LEN_W-1:0] take_len,
    input  logic             fire,
    output logic             busy,
    output logic [PW-1:0]    port,
    output logic             last
);

    // Words still to pass, header included.
    logic [LEN_W:0] rem;

    assign last = (rem == 1);

    always_ff @(posedge clk) begin
        if (rst) begin
            busy <= 1'b0;
            port <= '0;
            rem  <= '0;
        end else if (take) begin
            busy <= 1'b1;
            port <= take_port;
            rem  <= {1'b0, take_len} + 1'b1;
        end else if (fire) begin
            rem <= rem - 1'b1;
            if (rem == 1) busy <= 1'b0;
        end
    end

endmodule

// File: rtl/cnoc_node.sv
module cnoc_node
    import cnoc_pkg::*;
#(
    parameter  int NPORT = 4,
    localparam int PW    = (NPORT > 1) ? $clog2(NPORT) : 1
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic [NPORT-1:0][WORD_W-1:0] in_data,
    input  logic [NPORT-1:0]             in_exists,
    output logic [NPORT-1:0]             in_read,
    output logic [NPORT-1:0][WORD_W-1:0] out_data,
    output logic [NPORT-1:0]             out_write,
    input  logic [NPORT-1:0]             out_full,
    input  logic                         tbl_we,
    input  logic [RANK_W-1:0]            tbl_rank,
    input  logic [PW-1:0]                tbl_port
);

    logic [NPORT-1:0][RANK_W-1:0] lk_rank;
    logic [NPORT-1:0][PW-1:0]     lk_port;
    logic [NPORT-1:0]             in_busy, in_last, take, fire;
    logic [NPORT-1:0][PW-1:0]     in_port;
    logic [NPORT-1:0]             out_busy;
    logic [NPORT-1:0][PW-1:0]     out_own;
    logic [NPORT-1:0][NPORT-1:0]  req_m, gnt_m;
    logic [NPORT-1:0][PW-1:0]     gnt_idx;

    for (genvar i = 0; i < NPORT; i++) begin : g_rank
        assign lk_rank[i] = hdr_rank(in_data[i]);
    end

    cnoc_route_tbl #(.NPORT(NPORT)) u_tbl (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (tbl_we),
        .wr_rank (tbl_rank),
        .wr_port (tbl_port),
        .lk_rank (lk_rank),
        .lk_port (lk_port)
    );

    // Requests: an idle input with a header at its head asks its routed output.
    always_comb begin
        for (int o = 0; o < NPORT; o++) begin
            for (int i = 0; i < NPORT; i++) begin
                req_m[o][i] = in_exists[i] && !in_busy[i] && !out_busy[o]
                              && (int'(lk_port[i]) == o);
            end
        end
    end

    for (genvar o = 0; o < NPORT; o++) begin : g_arb
        cnoc_rr_arb #(.NPORT(NPORT)) u_arb (
            .clk     (clk),
            .rst     (rst),
            .req     (req_m[o]),
            .gnt     (gnt_m[o]),
            .gnt_idx (gnt_idx[o])
        );
    end

    always_comb begin
        for (int i = 0; i < NPORT; i++) begin
            take[i] = 1'b0;
            for (int o = 0; o < NPORT; o++) take[i] = take[i] | gnt_m[o][i];
            fire[i] = in_busy[i] && in_exists[i] && !out_full[in_port[i]];
        end
    end

    assign in_read = fire;

    for (genvar i = 0; i < NPORT; i++) begin : g_in
        cnoc_in_track #(.NPORT(NPORT)) u_trk (
            .clk       (clk),
            .rst       (rst),
            .take      (take[i]),
            .take_port (lk_port[i]),
            .take_len  (hdr_len(in_data[i])),
            .fire      (fire[i]),
            .busy      (in_busy[i]),
            .port      (in_port[i]),
            .last      (in_last[i])
        );
    end

    for (genvar o = 0; o < NPORT; o++) begin : g_out
        assign out_write[o] = out_busy[o] && fire[out_own[o]];
        assign out_data[o]  = in_data[out_own[o]];

        always_ff @(posedge clk) begin
            if (rst) begin
                out_busy[o] <= 1'b0;
                out_own[o]  <= '0;
            end else if (|gnt_m[o]) begin
                out_busy[o] <= 1'b1;
                out_own[o]  <= gnt_idx[o];
            end else if (out_write[o] && in_last[out_own[o]]) begin
                out_busy[o] <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/cnoc_node_chk.sv
module cnoc_node_chk
    import cnoc_pkg::*;
#(
    parameter  int NPORT = 4,
    localparam int PW    = (NPORT > 1) ? $clog2(NPORT) : 1
) (
    input logic                         clk,
    input logic                         rst,
    input logic [NPORT-1:0][WORD_W-1:0] in_data,
    input logic [NPORT-1:0]             in_exists,
    input logic [NPORT-1:0]             in_read,
    input logic [NPORT-1:0][WORD_W-1:0] out_data,
    input logic [NPORT-1:0]             out_write,
    input logic [NPORT-1:0]             out_full,
    input logic [NPORT-1:0]             out_busy,
    input logic [NPORT-1:0][PW-1:0]     out_own
);

    AST_RESET_QUIET: assert property (@(posedge clk) rst |-> (in_read == '0 && out_write == '0)); // R9

    AST_POP_EQ_PUSH: assert property (@(posedge clk) disable iff (rst)
        $countones(in_read) == $countones(out_write)); // R6

    for (genvar o = 0; o < NPORT; o++) begin : g_o
        AST_WRITE_NOT_FULL: assert property (@(posedge clk) disable iff (rst)
            out_write[o] |-> !out_full[o]); // R5
        AST_WRITE_FROM_OWNER: assert property (@(posedge clk) disable iff (rst)
            out_write[o] |-> (out_busy[o] && in_read[out_own[o]]
                              && out_data[o] == in_data[out_own[o]])); // R6
        AST_LOCK_HELD: assert property (@(posedge clk) disable iff (rst)
            (out_busy[o] && $past(out_busy[o])) |-> out_own[o] == $past(out_own[o])); // R7
    end

    for (genvar i = 0; i < NPORT; i++) begin : g_i
        AST_NO_POP_EMPTY: assert property (@(posedge clk) disable iff (rst)
            in_read[i] |-> in_exists[i]); // R6
    end

endmodule

bind cnoc_node cnoc_node_chk #(.NPORT(NPORT)) u_chk (.*);

// File: tb/test_cnoc_node.sv
module test_cnoc_node;
    import cnoc_pkg::*;

    localparam int NP         = 4;
    localparam int CLK_PERIOD = 10;

    logic                      clk = 1'b0;
    logic                      rst = 1'b1;
    logic [NP-1:0][WORD_W-1:0] in_data = '0;
    logic [NP-1:0]             in_exists = '0;
    logic [NP-1:0]             in_read;
    logic [NP-1:0][WORD_W-1:0] out_data;
    logic [NP-1:0]             out_write;
    logic [NP-1:0]             out_full = '0;
    logic                      tbl_we = 1'b0;
    logic [RANK_W-1:0]         tbl_rank = '0;
    logic [1:0]                tbl_port = '0;

    cnoc_node #(.NPORT(NP)) i_cnoc_node (.*);

    always #(CLK_PERIOD/2) clk = ~clk;

    logic [31:0] q_in  [NP][$];
    logic [31:0] exp_q [NP][NP][$];
    int          mdl_tbl [256];
    int          n_chk = 0, n_bad = 0, cyc = 0, seq = 0;
    int          rem [NP], cur [NP], hdr_cyc [NP], wr_cnt [NP];
    int          rr_log [$];
    int          wr_while_full = 0;
    logic [NP-1:0] full_force = '0;
    bit          done = 0;

    task automatic chk(bit ok, string req, longint act, longint expv);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, expv);
        end
    endtask

    // Scoreboard: match a header to a queued packet, then follow it word by word.
    task automatic monitor(int o, logic [31:0] d);
        int found;
        wr_cnt[o]++;
        if (rem[o] == 0) begin
            found = -1;
            for (int s = 0; s < NP; s++)
                if (found < 0 && exp_q[o][s].size() > 0 && exp_q[o][s][0] == d) found = s;
            chk(found >= 0, "R2 header on expected port", d, 0);
            if (found >= 0) begin
                void'(exp_q[o][found].pop_front());
                rem[o] = int'(d[7:0]);
                cur[o] = found;
                hdr_cyc[o] = cyc;
                if (o == 3) rr_log.push_back(found);
            end
        end else begin
            if (exp_q[o][cur[o]].size() > 0) begin
                chk(exp_q[o][cur[o]][0] == d, "R7 payload continuity", d, exp_q[o][cur[o]][0]);
                void'(exp_q[o][cur[o]].pop_front());
            end else begin
                chk(0, "R1 extra payload word", d, 0);
            end
            rem[o]--;
        end
    endtask

    // FIFO models: drive heads at the falling edge, sample just before the rising edge.
    initial begin
        for (int o = 0; o < NP; o++) begin rem[o] = 0; cur[o] = 0; hdr_cyc[o] = 0; wr_cnt[o] = 0; end
        forever begin
            @(negedge clk);
            cyc++;
            for (int i = 0; i < NP; i++) begin
                in_exists[i] = q_in[i].size() > 0;
                in_data[i]   = in_exists[i] ? q_in[i][0] : '0;
            end
            out_full = full_force;
            #(CLK_PERIOD/2 - 1);
            for (int i = 0; i < NP; i++) if (in_read[i]) void'(q_in[i].pop_front());
            for (int o = 0; o < NP; o++) if (out_write[o]) begin
                if (out_full[o]) wr_while_full++;
                monitor(o, out_data[o]);
            end
        end
    end

    task automatic send(int src, int dst, int len);
        logic [31:0] w;
        int p;
        seq++;
        p = mdl_tbl[dst];
        w = {8'(dst), 8'(src), 8'(seq), 8'(len)};
        q_in[src].push_back(w);
        exp_q[p][src].push_back(w);
        for (int k = 0; k < len; k++) begin
            w = {8'(src + 8'hC0), 8'(seq), 16'(k)};
            q_in[src].push_back(w);
            exp_q[p][src].push_back(w);
        end
    endtask

    task automatic tbl_write(int rank, int port);
        @(posedge clk); #1;
        tbl_we = 1'b1; tbl_rank = 8'(rank); tbl_port = 2'(port);
        @(posedge clk); #1;
        tbl_we = 1'b0;
        mdl_tbl[rank] = port;
    endtask

    function automatic bit all_empty();
        for (int i = 0; i < NP; i++) begin
            if (q_in[i].size() > 0) return 0;
            for (int s = 0; s < NP; s++) if (exp_q[i][s].size() > 0) return 0;
        end
        return 1;
    endfunction

    task automatic wait_idle(string req);
        int n = 0;
        while (!all_empty() && n < 2000) begin @(posedge clk); n++; end
        chk(all_empty(), req, n, 0);
        repeat (3) @(posedge clk);
    endtask

    task automatic report();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        report();
    end

    initial begin
        int p;
        int exp_rr [6];
        for (int r = 0; r < 256; r++) mdl_tbl[r] = 0;

        // R9 + R3: a packet waits during reset, then follows the default route to port 0.
        send(0, 77, 3);
        repeat (4) @(posedge clk);
        #1;
        chk(in_read == '0, "R9 no pop in reset", in_read, 0);
        chk(out_write == '0, "R9 no write in reset", out_write, 0);
        chk(q_in[0].size() == 4, "R9 input untouched", q_in[0].size(), 4);
        rst = 1'b0;
        wait_idle("R3 default route drains");
        chk(wr_cnt[0] == 4, "R3 words on port 0", wr_cnt[0], 4);

        // R4 + R10: zero-length packet, cut-through latency.
        @(posedge clk);
        p = cyc;
        send(1, 77, 0);
        wait_idle("R10 header-only packet");
        chk(hdr_cyc[0] == p + 2, "R4 header latency", hdr_cyc[0], p + 2);
        chk(rem[0] == 0, "R10 port free after header", rem[0], 0);

        // R2: program ranks 0..7 to port rank mod 4, then mixed traffic.
        for (int r = 0; r < 8; r++) tbl_write(r, r % 4);
        @(posedge clk);
        send(0, 1, 5); send(1, 2, 0); send(2, 1, 7); send(3, 0, 2); send(0, 6, 3);
        send(1, 4, 1); send(3, 5, 4);
        wait_idle("R2 routed traffic drains");

        // R8: three inputs contend for port 3, two packets each.
        @(posedge clk);
        for (int k = 0; k < 2; k++) for (int s = 0; s < 3; s++) send(s, 3, 2);
        wait_idle("R8 contended traffic drains");
        exp_rr = '{0, 1, 2, 0, 1, 2};
        chk(rr_log.size() == 6, "R8 grant count", rr_log.size(), 6);
        for (int k = 0; k < 6 && k < rr_log.size(); k++)
            chk(rr_log[k] == exp_rr[k], "R8 grant order", rr_log[k], exp_rr[k]);

        // R5: a full output stalls its owner; nothing is popped or written.
        @(posedge clk);
        full_force[1] = 1'b1;
        p = wr_cnt[1];
        send(0, 1, 20); send(2, 5, 40);
        repeat (20) @(posedge clk);
        chk(q_in[0].size() + q_in[2].size() == 62, "R5 inputs held while full",
            q_in[0].size() + q_in[2].size(), 62);
        chk(wr_cnt[1] == p, "R5 no write while full", wr_cnt[1], p);

        // R7: toggling backpressure with two long packets on one port.
        for (int k = 0; k < 60; k++) begin @(posedge clk); full_force[1] = (k % 3 == 0); end
        full_force[1] = 1'b0;
        wait_idle("R7 interleave-free drain");

        // R2: rewrite an entry and check the new route.
        tbl_write(5, 3);
        @(posedge clk);
        p = wr_cnt[3];
        send(1, 5, 1);
        wait_idle("R2 rewritten route drains");
        chk(wr_cnt[3] == p + 2, "R2 new route used", wr_cnt[3], p + 2);

        chk(wr_while_full == 0, "R5 writes seen while full", wr_while_full, 0);
        chk(all_empty(), "R6 every word delivered", 0, 0);
        report();
    end

endmodule